// File: doc/BRIEF.md
# Integer Multiply and Divide Unit

This unit performs the eight integer multiply and divide operations of a 32-bit processor pipeline: the low-word product, three high-word products with different operand signedness, and signed and unsigned quotient and remainder. The pipeline presents a 3-bit operation code and two operands with a one-cycle start strobe. It then watches `ready`. While `ready` is low, the pipeline holds its program counter and blocks the register-file write.

Products are combinational. They appear in the same cycle and never drop `ready`. Division runs on a shared restoring core. The first busy cycle loads the operand magnitudes. The next 32 cycles each produce one quotient bit by trial subtraction. On the way out, the raw quotient and remainder get sign correction and the special-case results. The result stays valid until the next accepted division. Choosing the quotient or the remainder follows the operation code presented at the time.

Top module: `muldiv_unit`

## Requirements
- R1: After reset `ready` is 1 and no operation is in progress.
- R2: With op=0 (low product), `result` is bits 31:0 of a×b in the same cycle.
- R3: With op=1 (high product, both signed), `result` is bits 63:32 of the signed 64-bit product.
- R4: With op=2 (high product, a signed, b unsigned), `result` is bits 63:32 of that mixed-sign product.
- R5: With op=3 (high product, both unsigned), `result` is bits 63:32 of the unsigned product.
- R6: A start with op 0–3 never lowers `ready`.
- R7: A start with op 4–7 while `ready` is 1 lowers `ready` at that clock edge. `ready` then stays low for exactly 33 cycles: one load cycle and 32 iteration cycles.
- R8: With op=5 (unsigned quotient) or op=7 (unsigned remainder), `result` after the division is a/b or a mod b.
- R9: With op=4 (signed quotient), the result is truncated toward zero: it is the quotient of the magnitudes, negated when the operand signs differ.
- R10: With op=6 (signed remainder), the result takes the sign of the dividend.
- R11: For a divisor of zero, the quotient is all ones and the remainder equals the dividend, for both signed and unsigned operations.
- R12: The signed division of 0x80000000 by 0xFFFFFFFF gives a quotient of 0x80000000 and a remainder of 0.
- R13: A start while `ready` is 0 is ignored: the division in progress keeps its operands and its completion time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle strobe that starts an operation |
| op | input | 3 | Operation code: 0 low product, 1/2/3 high product (ss/su/uu), 4 div, 5 divu, 6 rem, 7 remu |
| opnd_a | input | 32 | First source operand (multiplicand or dividend) |
| opnd_b | input | 32 | Second source operand (multiplier or divisor) |
| result | output | 32 | Product, quotient or remainder |
| ready | output | 1 | High when `result` is valid; low while a division is in flight |

## Verification
The assertions assume that a start strobe lasts one cycle and that a division start is presented only while `ready` is high. The one exception is the deliberate overlap case, where the checker expects the latched operands to stay frozen. The result checks also assume the operation code is held steady until `ready` returns, because the quotient/remainder choice follows the live code. The bench drives every input on the falling clock edge, keeps `op` fixed for the whole stall, and drops `start` after one cycle. The only start raised during a stall is the one that tests R13.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  localparam int unsigned MD_XLEN = 32;

  typedef enum logic [2:0] {
    MD_MUL    = 3'd0,
    MD_MULHSS = 3'd1,
    MD_MULHSU = 3'd2,
    MD_MULHUU = 3'd3,
    MD_DIVS   = 3'd4,
    MD_DIVU   = 3'd5,
    MD_REMS   = 3'd6,
    MD_REMU   = 3'd7
  } md_op_e;

  // bit 2 selects the divider, bit 0 clear means signed divide, bit 1 picks remainder
  function automatic logic op_is_div(input logic [2:0] code);
    return code[2];
  endfunction

  function automatic logic op_div_signed(input logic [2:0] code);
    return code[2] & ~code[0];
  endfunction

  function automatic logic op_wants_rem(input logic [2:0] code);
    return code[1];
  endfunction

endpackage

// File: rtl/muldiv_mul_unit.sv
module muldiv_mul_unit #(
  parameter int unsigned XLEN = 32
) (
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] mul_x,
  input  logic [XLEN-1:0] mul_y,
  output logic [XLEN-1:0] mul_res
);

  localparam int unsigned PW = 2 * XLEN;

  // sign-extend each operand by one bit according to its signedness, then multiply
  function automatic logic [PW-1:0] wide_product(
    input logic [XLEN-1:0] x,
    input logic [XLEN-1:0] y,
    input logic            x_signed,
    input logic            y_signed
  );
    logic [XLEN:0]         xe;
    logic [XLEN:0]         ye;
    logic signed [PW+1:0]  xw;
    logic signed [PW+1:0]  yw;
    logic signed [PW+1:0]  pw;
    xe = {x_signed & x[XLEN-1], x};
    ye = {y_signed & y[XLEN-1], y};
    xw = $signed({{(XLEN+1){xe[XLEN]}}, xe});
    yw = $signed({{(XLEN+1){ye[XLEN]}}, ye});
    pw = xw * yw;
    return pw[PW-1:0];
  endfunction

  logic          sgn_x;
  logic          sgn_y;
  logic [PW-1:0] product;

  always_comb begin
    sgn_x = (op == 3'd1) || (op == 3'd2);
    sgn_y = (op == 3'd1);
  end

  assign product = wide_product(mul_x, mul_y, sgn_x, sgn_y);
  assign mul_res = (op == 3'd0) ? product[XLEN-1:0] : product[PW-1:XLEN];

endmodule

// File: rtl/muldiv_div_core.sv
module muldiv_div_core #(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              want_signed,
  input  logic [XLEN-1:0]   in_a,
  input  logic [XLEN-1:0]   in_b,
  output logic [$clog2(XLEN+2)-1:0] iter_cnt,
  output logic [XLEN-1:0]   snap_a,
  output logic [XLEN-1:0]   snap_b,
  output logic              snap_signed,
  output logic [XLEN-1:0]   uquot,
  output logic [XLEN-1:0]   urem
);

  localparam int unsigned CW = $clog2(XLEN + 2);
  localparam logic [CW-1:0] CNT_LOAD = CW'(1);
  localparam logic [CW-1:0] CNT_LAST = CW'(XLEN + 1);

  function automatic logic [XLEN-1:0] magnitude(input logic [XLEN-1:0] v, input logic sgn);
    return (sgn && v[XLEN-1]) ? (~v + 1'b1) : v;
  endfunction

  logic [XLEN-1:0] dq;
  logic [XLEN:0]   dr;
  logic [XLEN-1:0] db;

  // one restoring step: shift in the dividend msb, try subtracting the divisor
  logic [XLEN:0] shifted_rem;
  logic [XLEN:0] trial;
  logic          trial_neg;
  logic          quot_bit;

  assign shifted_rem = {dr[XLEN-1:0], dq[XLEN-1]};
  assign trial       = shifted_rem - {1'b0, db};
  assign trial_neg   = trial[XLEN];
  assign quot_bit    = ~trial_neg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iter_cnt    <= '0;
      snap_a      <= '0;
      snap_b      <= '0;
      snap_signed <= 1'b0;
      dq          <= '0;
      dr          <= '0;
      db          <= '0;
    end else if (accept) begin
      iter_cnt    <= CNT_LOAD;
      snap_a      <= in_a;
      snap_b      <= in_b;
      snap_signed <= want_signed;
    end else if (iter_cnt == CNT_LOAD) begin
      dq       <= magnitude(snap_a, snap_signed);
      db       <= magnitude(snap_b, snap_signed);
      dr       <= '0;
      iter_cnt <= iter_cnt + 1'b1;
    end else if (iter_cnt != '0) begin
      dq       <= {dq[XLEN-2:0], quot_bit};
      dr       <= trial_neg ? shifted_rem : trial;
      iter_cnt <= (iter_cnt == CNT_LAST) ? '0 : iter_cnt + 1'b1;
    end
  end

  assign uquot = dq;
  assign urem  = dr[XLEN-1:0];

endmodule

// File: rtl/muldiv_sign_fix.sv
module muldiv_sign_fix #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] uquot,
  input  logic [XLEN-1:0] urem,
  input  logic [XLEN-1:0] snap_a,
  input  logic [XLEN-1:0] snap_b,
  input  logic            snap_signed,
  output logic [XLEN-1:0] quot_fin,
  output logic [XLEN-1:0] rem_fin
);

  function automatic logic [XLEN-1:0] cond_negate(input logic [XLEN-1:0] v, input logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  logic by_zero;
  logic neg_quot;
  logic neg_rem;

  assign by_zero  = (snap_b == '0);
  assign neg_quot = snap_signed & (snap_a[XLEN-1] ^ snap_b[XLEN-1]);
  assign neg_rem  = snap_signed & snap_a[XLEN-1];

  assign quot_fin = by_zero ? '1     : cond_negate(uquot, neg_quot);
  assign rem_fin  = by_zero ? snap_a : cond_negate(urem, neg_rem);

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int unsigned XLEN = MD_XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  output logic [XLEN-1:0] result,
  output logic            ready
);

  localparam int unsigned CW = $clog2(XLEN + 2);

  logic [CW-1:0]   iter_cnt;
  logic [XLEN-1:0] snap_a;
  logic [XLEN-1:0] snap_b;
  logic            snap_signed;
  logic [XLEN-1:0] uquot;
  logic [XLEN-1:0] urem;
  logic [XLEN-1:0] quot_fin;
  logic [XLEN-1:0] rem_fin;
  logic [XLEN-1:0] mul_res;
  logic            div_accept;

  assign ready      = (iter_cnt == '0);
  assign div_accept = start & ready & op_is_div(op);

  muldiv_mul_unit #(.XLEN(XLEN)) i_mul (
    .op      (op),
    .mul_x   (opnd_a),
    .mul_y   (opnd_b),
    .mul_res (mul_res)
  );

  muldiv_div_core #(.XLEN(XLEN)) i_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (div_accept),
    .want_signed (op_div_signed(op)),
    .in_a        (opnd_a),
    .in_b        (opnd_b),
    .iter_cnt    (iter_cnt),
    .snap_a      (snap_a),
    .snap_b      (snap_b),
    .snap_signed (snap_signed),
    .uquot       (uquot),
    .urem        (urem)
  );

  muldiv_sign_fix #(.XLEN(XLEN)) i_fix (
    .uquot       (uquot),
    .urem        (urem),
    .snap_a      (snap_a),
    .snap_b      (snap_b),
    .snap_signed (snap_signed),
    .quot_fin    (quot_fin),
    .rem_fin     (rem_fin)
  );

  always_comb begin
    if (!op_is_div(op))         result = mul_res;
    else if (op_wants_rem(op))  result = rem_fin;
    else                        result = quot_fin;
  end

endmodule

// File: rtl/muldiv_checker.sv
module muldiv_checker #(
  parameter int unsigned XLEN = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start,
  input logic [2:0]                op,
  input logic                      ready,
  input logic [$clog2(XLEN+2)-1:0] iter_cnt,
  input logic [XLEN-1:0]           snap_a,
  input logic [XLEN-1:0]           snap_b,
  input logic                      snap_signed,
  input logic [XLEN-1:0]           quot_fin
);

  localparam int unsigned CW = $clog2(XLEN + 2);
  localparam logic [CW-1:0] LAST = CW'(XLEN + 1);
  localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

  AST_MUL_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ready && start && !op[2] |=> ready); // R6

  AST_DIV_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    ready && start && op[2] |=> !ready && iter_cnt == CW'(1)); // R7

  AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    iter_cnt != '0 && iter_cnt != LAST |=> iter_cnt == $past(iter_cnt) + 1'b1); // R7

  AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    iter_cnt == LAST |=> ready); // R7

  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(snap_a) && $stable(snap_b) && $stable(snap_signed)); // R13

  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    iter_cnt == LAST && snap_b == '0 |=> quot_fin == '1); // R11

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    iter_cnt == LAST && snap_signed && snap_a == MOST_NEG && snap_b == '1
    |=> quot_fin == MOST_NEG); // R12

endmodule

bind muldiv_unit muldiv_checker #(.XLEN(XLEN)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .op          (op),
  .ready       (ready),
  .iter_cnt    (iter_cnt),
  .snap_a      (snap_a),
  .snap_b      (snap_b),
  .snap_signed (snap_signed),
  .quot_fin    (quot_fin)
);

// File: tb/test_muldiv_unit.sv
`timescale 1ns/1ps
module test_muldiv_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [31:0] result;
  logic        ready;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  muldiv_unit i_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .ready(ready)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_mul(input logic [2:0] code, input logic [31:0] a, input logic [31:0] b);
    longint      sp;
    logic [63:0] up;
    case (code)
      3'd0: begin up = {32'd0, a} * {32'd0, b}; return up[31:0]; end
      3'd1: begin sp = longint'($signed(a)) * longint'($signed(b)); return sp[63:32]; end
      3'd2: begin sp = longint'($signed(a)) * longint'({32'd0, b}); return sp[63:32]; end
      default: begin up = {32'd0, a} * {32'd0, b}; return up[63:32]; end
    endcase
  endfunction

  function automatic logic [31:0] exp_div(input logic [2:0] code, input logic [31:0] a, input logic [31:0] b);
    logic is_rem;
    logic sgn;
    is_rem = (code == 3'd6) || (code == 3'd7);
    sgn    = (code == 3'd4) || (code == 3'd6);
    if (b == 32'd0) return is_rem ? a : 32'hFFFF_FFFF;
    if (sgn && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return is_rem ? 32'd0 : 32'h8000_0000;
    if (sgn) return is_rem ? 32'($signed(a) % $signed(b)) : 32'($signed(a) / $signed(b));
    return is_rem ? a % b : a / b;
  endfunction

  task automatic run_mul(input logic [2:0] code, input logic [31:0] a, input logic [31:0] b, input string req);
    @(negedge clk);
    op = code; opnd_a = a; opnd_b = b; start = 1'b1;
    #1;
    check(result == exp_mul(code, a, b), req, result, exp_mul(code, a, b));
    @(negedge clk);
    start = 1'b0;
    check(ready == 1'b1, "R6", {31'd0, ready}, 32'd1);
  endtask

  // starts a division, optionally raises a second start mid-flight, counts the stall
  task automatic run_div(input logic [2:0] code, input logic [31:0] a, input logic [31:0] b,
                         input string req, input logic poke);
    int low_cycles;
    low_cycles = 0;
    @(negedge clk);
    op = code; opnd_a = a; opnd_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!ready && low_cycles < 100) begin
      low_cycles++;
      if (poke && low_cycles == 10) begin
        opnd_a = ~a; opnd_b = b + 32'd7; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(low_cycles == 33, poke ? "R13" : "R7", 32'(low_cycles), 32'd33);
    check(result == exp_div(code, a, b), req, result, exp_div(code, a, b));
  endtask

  task automatic test_reset();
    #1;
    check(ready == 1'b1, "R1", {31'd0, ready}, 32'd1);
  endtask

  task automatic test_products();
    run_mul(3'd0, 32'h1234_5678, 32'h9ABC_DEF0, "R2");
    run_mul(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
    run_mul(3'd1, 32'hFFFF_FFFE, 32'h0000_0003, "R3");
    run_mul(3'd1, 32'h8000_0000, 32'h8000_0000, "R3");
    run_mul(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");
    run_mul(3'd2, 32'h7FFF_FFFF, 32'h8000_0001, "R4");
    run_mul(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5");
    run_mul(3'd3, 32'h8000_0000, 32'h0000_0002, "R5");
  endtask

  task automatic test_unsigned_div();
    run_div(3'd5, 32'hF0F0_F0FE, 32'h0000_0003, "R8", 1'b0);
    run_div(3'd7, 32'hF0F0_F0FE, 32'h0000_0007, "R8", 1'b0);
    run_div(3'd5, 32'h0000_0005, 32'hFFFF_FFFF, "R8", 1'b0);
  endtask

  task automatic test_signed_div();
    run_div(3'd4, 32'hFFFF_FFF9, 32'h0000_0002, "R9", 1'b0);   // -7/2 = -3
    run_div(3'd4, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R9", 1'b0);   // -7/-2 = 3
    run_div(3'd6, 32'hFFFF_FFF9, 32'h0000_0002, "R10", 1'b0);  // -7%2 = -1
    run_div(3'd6, 32'h0000_0007, 32'hFFFF_FFFE, "R10", 1'b0);  // 7%-2 = 1
  endtask

  task automatic test_zero_divisor();
    run_div(3'd5, 32'h1357_9BDF, 32'h0, "R11", 1'b0);
    run_div(3'd4, 32'hFFFF_FF00, 32'h0, "R11", 1'b0);
    run_div(3'd6, 32'hFFFF_FF00, 32'h0, "R11", 1'b0);
    run_div(3'd7, 32'h1357_9BDF, 32'h0, "R11", 1'b0);
  endtask

  task automatic test_overflow();
    run_div(3'd4, 32'h8000_0000, 32'hFFFF_FFFF, "R12", 1'b0);
    run_div(3'd6, 32'h8000_0000, 32'hFFFF_FFFF, "R12", 1'b0);
  endtask

  task automatic test_busy_start();
    run_div(3'd5, 32'h0001_0000, 32'h0000_0010, "R13", 1'b1);
  endtask

  initial begin
    #12 rst_n = 1'b1;
    test_reset();
    test_products();
    test_unsigned_div();
    test_signed_div();
    test_zero_divisor();
    test_overflow();
    test_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule